// File: doc/BRIEF.md
# Floppy DMA Channel Register Block

This block holds the programming state for one DMA channel that serves a floppy disk controller inside a peripheral I/O controller. Software reaches it through a byte-wide register port. The port can set a shared DMA base address, a channel address pointer, a 16-bit byte count and an 8-bit control/status byte. Multi-byte registers are big-endian: the lowest byte offset of a register holds its most significant byte.

The outputs are the live pointer, the live count, the RUN and direction flags, and an interrupt request. The interrupt request goes high when the completion flag and the interrupt enable are both set. A transfer-done pulse from the data mover sets the completion flag while RUN is on.

A control write with bit 0 set performs a soft reset. It reloads the pointer from the 256 KiB-aligned base plus a fixed offset, and it clears the count. Moving data and mastering the bus are the job of other logic.

Top module: `fdma_regs`

## Requirements
- R1: After hardware reset, every register is zero, so every register read returns 0x00 and the outputs `ptr_out`, `cnt_out`, `run`, `dir` and `irq` are all zero.
- R2: The base address occupies offsets 0x31000 to 0x31003. Offset 0x31000 holds bits 31:24 and offset 0x31003 holds bits 7:0. Each write updates one byte and then forces bits 17:0 to zero. A read returns the stored byte of that lane.
- R3: The channel pointer occupies offsets 0x32060 to 0x32063, with the same byte order as the base address. It is written and read one byte at a time and appears on `ptr_out`.
- R4: The byte count is written at 0x32064 (bits 15:8) and 0x32065 (bits 7:0). It reads back at the same offsets and appears on `cnt_out`.
- R5: The control/status register is at offset 0x32068. Every write to it loads bit 6 (interrupt enable) and bit 3 (direction, shown on `dir`) from the written byte.
- R6: A control write with bit 0 = 1 clears bits 7, 1 and 0 and leaves only bits 6 and 3 set as written. It also loads the pointer with base + 0x15000 and sets the count to 0.
- R7: A control write with bit 0 = 0 loads bit 1 (RUN, shown on `run`) from the written byte. A 1 in bit 7 of that write clears the completion flag, and a 0 leaves the flag unchanged.
- R8: A one-cycle `xfer_done` pulse sets bit 7 when RUN is 1. When RUN is 0, the pulse has no effect.
- R9: `irq` is high exactly when control bits 7 and 6 are both 1.
- R10: A read at any offset outside the mapped registers returns 0x00, and a write there changes nothing.
- R11: When a write-one-to-clear of bit 7 and a `xfer_done` pulse with RUN = 1 arrive in the same cycle, bit 7 ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous hardware reset |
| reg_addr | input | 20 | Byte offset of the register access |
| reg_wr | input | 1 | Write strobe, one byte per cycle |
| reg_wdata | input | 8 | Write data byte |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| xfer_done | input | 1 | Transfer completion pulse from the data mover |
| ptr_out | output | 32 | Current channel address pointer |
| cnt_out | output | 16 | Current byte count |
| run | output | 1 | Channel RUN flag (control bit 1) |
| dir | output | 1 | Transfer direction (control bit 3) |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is the collision between a write-one-to-clear and a completion pulse in the same cycle. To reach it, the bench first sets RUN and lets the flag be set. It then issues a control write with bit 7 set in the same cycle as a `xfer_done` pulse, and reads the control byte back.

The soft-reload target depends on the base masking, so the bench programs a base whose low bytes are not aligned. It then checks the reloaded pointer against base & 0xFFFC0000 plus the reload offset. It also checks that a completion pulse with RUN off leaves the status byte and `irq` unchanged.

// File: rtl/fdma_pkg.sv
package fdma_pkg;

   typedef enum logic [2:0] {
      SEL_NONE = 3'd0,
      SEL_BASE = 3'd1,
      SEL_PTR  = 3'd2,
      SEL_CNT  = 3'd3,
      SEL_CTRL = 3'd4
   } fdma_sel_e;

   // control/status bit positions
   localparam int CS_RST  = 0;
   localparam int CS_RUN  = 1;
   localparam int CS_DIR  = 3;
   localparam int CS_IE   = 6;
   localparam int CS_FLAG = 7;

   // bits a control write always copies
   localparam logic [7:0] CS_COPY_MASK = 8'h48;

endpackage

// File: rtl/fdma_decode.sv
module fdma_decode
   import fdma_pkg::*;
#(
   parameter int              ADDR_W    = 20,
   parameter logic [ADDR_W-1:0] BASE_ADR = 20'h31000,
   parameter logic [ADDR_W-1:0] PTR_ADR  = 20'h32060,
   parameter logic [ADDR_W-1:0] CNT_ADR  = 20'h32064,
   parameter logic [ADDR_W-1:0] CTRL_ADR = 20'h32068
) (
   input  logic [ADDR_W-1:0] addr,
   output fdma_sel_e         sel,
   output logic [1:0]        lane
);

   localparam logic [ADDR_W-1:0] WORD_SPAN = ADDR_W'(4);
   localparam logic [ADDR_W-1:0] HALF_SPAN = ADDR_W'(2);

   logic in_base, in_ptr, in_cnt, in_ctrl;
   logic [ADDR_W-1:0] d_base, d_ptr, d_cnt;

   always_comb begin
      d_base  = addr - BASE_ADR;
      d_ptr   = addr - PTR_ADR;
      d_cnt   = addr - CNT_ADR;
      in_base = (addr >= BASE_ADR) && (d_base < WORD_SPAN);
      in_ptr  = (addr >= PTR_ADR)  && (d_ptr  < WORD_SPAN);
      in_cnt  = (addr >= CNT_ADR)  && (d_cnt  < HALF_SPAN);
      in_ctrl = (addr == CTRL_ADR);
      sel  = SEL_NONE;
      lane = 2'd0;
      if (in_base) begin
         sel  = SEL_BASE;
         lane = d_base[1:0];
      end else if (in_ptr) begin
         sel  = SEL_PTR;
         lane = d_ptr[1:0];
      end else if (in_cnt) begin
         sel  = SEL_CNT;
         lane = d_cnt[1:0];
      end else if (in_ctrl) begin
         sel  = SEL_CTRL;
      end
   end

   // regions must not overlap
   if ((PTR_ADR + WORD_SPAN) > CNT_ADR) begin : g_bad_ptr
      $error("fdma_decode: pointer window overlaps count window");
   end
   if ((CNT_ADR + HALF_SPAN) > CTRL_ADR) begin : g_bad_cnt
      $error("fdma_decode: count window overlaps control offset");
   end

endmodule

// File: rtl/fdma_lane_reg.sv
module fdma_lane_reg #(
   parameter int NB        = 4,
   parameter int ZERO_LSBS = 0,
   parameter int LW        = (NB > 1) ? $clog2(NB) : 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [LW-1:0]   wr_lane,
   input  logic [7:0]      wdata,
   input  logic            ld_en,
   input  logic [NB*8-1:0] ld_val,
   input  logic [LW-1:0]   rd_lane,
   output logic [7:0]      rd_byte,
   output logic [NB*8-1:0] q
);

   localparam int          W    = NB * 8;
   localparam logic [W-1:0] KEEP = {W{1'b1}} << ZERO_LSBS;

   if (NB < 1 || NB > 4) begin : g_bad_nb
      $error("fdma_lane_reg: NB must be 1..4");
   end
   if (ZERO_LSBS < 0 || ZERO_LSBS >= W) begin : g_bad_zero
      $error("fdma_lane_reg: ZERO_LSBS out of range");
   end

   logic [W-1:0] nxt;

   // big-endian: lane 0 is the most significant byte
   for (genvar i = 0; i < NB; i++) begin : g_lane
      assign nxt[(NB-1-i)*8 +: 8] = (wr_en && (wr_lane == LW'(i))) ? wdata
                                                                      : q[(NB-1-i)*8 +: 8];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q <= '0;
      else if (ld_en)  q <= ld_val & KEEP;
      else             q <= nxt & KEEP;
   end

   always_comb begin
      rd_byte = 8'h00;
      for (int j = 0; j < NB; j++) begin
         if (rd_lane == LW'(j)) rd_byte = q[(NB-1-j)*8 +: 8];
      end
   end

   // R2: cleared low bits never hold a one
   if (ZERO_LSBS > 0) begin : g_zero_chk
      align_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (q & ~KEEP) == '0);
   end

endmodule

// File: rtl/fdma_ctrl.sv
module fdma_ctrl
   import fdma_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic [7:0] wdata,
   input  logic       done,
   output logic [7:0] cs,
   output logic       soft_rst
);

   logic [7:0] nxt;
   logic       flag_set;

   assign soft_rst = wr_en && wdata[CS_RST];
   assign flag_set = done && cs[CS_RUN];

   always_comb begin
      nxt = cs;
      if (wr_en) begin
         nxt = (cs & ~CS_COPY_MASK) | (wdata & CS_COPY_MASK);
         if (wdata[CS_RST]) begin
            nxt = wdata & CS_COPY_MASK;
         end else begin
            nxt[CS_RUN] = wdata[CS_RUN];
            nxt[CS_RST] = 1'b0;
            if (wdata[CS_FLAG]) nxt[CS_FLAG] = 1'b0;
         end
      end
      // a completion in the same cycle overrides any clear
      if (flag_set) nxt[CS_FLAG] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cs <= 8'h00;
      else        cs <= nxt;
   end

   // R5
   copy_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (cs[CS_IE] == $past(wdata[CS_IE])) && (cs[CS_DIR] == $past(wdata[CS_DIR])));
   // R6
   soft_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wdata[CS_RST] && !(done && cs[CS_RUN])) |=> cs == ($past(wdata) & 8'h48));
   // R11
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && cs[CS_RUN]) |=> cs[CS_FLAG]);
   // R8
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && !(done && cs[CS_RUN])) |=> $stable(cs));

endmodule

// File: rtl/fdma_regs.sv
module fdma_regs
   import fdma_pkg::*;
#(
   parameter int                ADDR_W     = 20,
   parameter logic [ADDR_W-1:0] BASE_ADR   = 20'h31000,
   parameter logic [ADDR_W-1:0] PTR_ADR    = 20'h32060,
   parameter logic [ADDR_W-1:0] CNT_ADR    = 20'h32064,
   parameter logic [ADDR_W-1:0] CTRL_ADR   = 20'h32068,
   parameter int                ALIGN_BITS = 18,
   parameter logic [31:0]       RELOAD_OFS = 32'h0001_5000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic [7:0]        reg_wdata,
   output logic [7:0]        reg_rdata,
   input  logic              xfer_done,
   output logic [31:0]       ptr_out,
   output logic [15:0]       cnt_out,
   output logic              run,
   output logic              dir,
   output logic              irq
);

   if (RELOAD_OFS >= (32'd1 << ALIGN_BITS)) begin : g_bad_reload
      $error("fdma_regs: reload offset must lie inside one aligned window");
   end

   fdma_sel_e  sel;
   logic [1:0] lane;
   logic [31:0] base_q;
   logic [7:0] base_rd, ptr_rd, cnt_rd, cs;
   logic       soft_rst;

   fdma_decode #(
      .ADDR_W(ADDR_W), .BASE_ADR(BASE_ADR), .PTR_ADR(PTR_ADR),
      .CNT_ADR(CNT_ADR), .CTRL_ADR(CTRL_ADR)
   ) u_dec (
      .addr(reg_addr), .sel(sel), .lane(lane)
   );

   fdma_lane_reg #(.NB(4), .ZERO_LSBS(ALIGN_BITS)) u_base (
      .clk(clk), .rst_n(rst_n),
      .wr_en(reg_wr && sel == SEL_BASE), .wr_lane(lane), .wdata(reg_wdata),
      .ld_en(1'b0), .ld_val(32'h0),
      .rd_lane(lane), .rd_byte(base_rd), .q(base_q)
   );

   fdma_lane_reg #(.NB(4), .ZERO_LSBS(0)) u_ptr (
      .clk(clk), .rst_n(rst_n),
      .wr_en(reg_wr && sel == SEL_PTR), .wr_lane(lane), .wdata(reg_wdata),
      .ld_en(soft_rst), .ld_val(base_q + RELOAD_OFS),
      .rd_lane(lane), .rd_byte(ptr_rd), .q(ptr_out)
   );

   fdma_lane_reg #(.NB(2), .ZERO_LSBS(0)) u_cnt (
      .clk(clk), .rst_n(rst_n),
      .wr_en(reg_wr && sel == SEL_CNT), .wr_lane(lane[0]), .wdata(reg_wdata),
      .ld_en(soft_rst), .ld_val(16'h0000),
      .rd_lane(lane[0]), .rd_byte(cnt_rd), .q(cnt_out)
   );

   fdma_ctrl u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .wr_en(reg_wr && sel == SEL_CTRL), .wdata(reg_wdata),
      .done(xfer_done), .cs(cs), .soft_rst(soft_rst)
   );

   always_comb begin
      unique case (sel)
         SEL_BASE: reg_rdata = base_rd;
         SEL_PTR:  reg_rdata = ptr_rd;
         SEL_CNT:  reg_rdata = cnt_rd;
         SEL_CTRL: reg_rdata = cs;
         default:  reg_rdata = 8'h00;
      endcase
   end

   assign run = cs[CS_RUN];
   assign dir = cs[CS_DIR];
   assign irq = cs[CS_FLAG] && cs[CS_IE];

   // R6
   reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (cnt_out == 16'h0) && (ptr_out == $past(base_q) + RELOAD_OFS));
   // R9
   irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> (cs[CS_IE] && ($rose(cs[CS_FLAG]) || $rose(cs[CS_IE]))));
   // R10
   unmapped_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && sel == SEL_NONE) |=> $stable(base_q) && (xfer_done || $stable(cs)));

endmodule

// File: tb/fdma_regs_bench.sv
module fdma_regs_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [19:0] reg_addr = '0;
   logic        reg_wr = 1'b0;
   logic [7:0]  reg_wdata = '0;
   logic [7:0]  reg_rdata;
   logic        xfer_done = 1'b0;
   logic [31:0] ptr_out;
   logic [15:0] cnt_out;
   logic        run, dir, irq;

   int checks = 0;
   int errors = 0;
   bit finished = 0;
   logic rd_v = 1'b0;

   typedef struct {
      string       tag;
      logic [19:0] addr;
      logic [7:0]  exp;
   } item_t;
   item_t exp_q[$];

   always #4 clk = ~clk;

   fdma_regs u_fdma_regs (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .xfer_done(xfer_done),
      .ptr_out(ptr_out), .cnt_out(cnt_out), .run(run), .dir(dir), .irq(irq)
   );

   // monitor: compare read data with the scoreboard head
   always @(posedge clk) begin
      if (rd_v && exp_q.size() > 0) begin
         item_t it;
         it = exp_q.pop_front();
         checks++;
         if (reg_rdata !== it.exp) begin
            errors++;
            $display("FAIL %s read @%h: got %h expected %h", it.tag, it.addr, reg_rdata, it.exp);
         end
      end
   end

   task automatic wr(input logic [19:0] a, input logic [7:0] d, input logic dn = 1'b0);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1; xfer_done = dn;
      @(negedge clk);
      reg_wr = 1'b0; xfer_done = 1'b0;
   endtask

   task automatic pulse_done();
      @(negedge clk);
      xfer_done = 1'b1;
      @(negedge clk);
      xfer_done = 1'b0;
   endtask

   task automatic rd(input logic [19:0] a, input logic [7:0] e, input string tag);
      item_t it;
      @(negedge clk);
      reg_addr = a;
      it.tag = tag; it.addr = a; it.exp = e;
      exp_q.push_back(it);
      rd_v = 1'b1;
      @(negedge clk);
      rd_v = 1'b0;
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] e);
      checks++;
      if (act !== e) begin
         errors++;
         $display("FAIL %s: got %h expected %h", tag, act, e);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 ptr", ptr_out, 0);
      chk("R1 cnt", {16'h0, cnt_out}, 0);
      chk("R1 flags", {29'h0, run, dir, irq}, 0);
      rd(20'h32068, 8'h00, "R1 ctrl");
      rd(20'h31000, 8'h00, "R1 base");

      // R2 base write, alignment mask
      wr(20'h31000, 8'h12); wr(20'h31001, 8'h37);
      wr(20'h31002, 8'h56); wr(20'h31003, 8'h78);
      rd(20'h31000, 8'h12, "R2 b0");
      rd(20'h31001, 8'h34, "R2 b1 masked");
      rd(20'h31002, 8'h00, "R2 b2 masked");
      rd(20'h31003, 8'h00, "R2 b3 masked");

      // R3 pointer
      wr(20'h32060, 8'hDE); wr(20'h32061, 8'hAD);
      wr(20'h32062, 8'hBE); wr(20'h32063, 8'hEF);
      chk("R3 ptr_out", ptr_out, 32'hDEADBEEF);
      rd(20'h32061, 8'hAD, "R3 p1");
      rd(20'h32063, 8'hEF, "R3 p3");

      // R4 count
      wr(20'h32064, 8'hA5); wr(20'h32065, 8'h3C);
      chk("R4 cnt_out", {16'h0, cnt_out}, 32'h0000A53C);
      rd(20'h32064, 8'hA5, "R4 hi");
      rd(20'h32065, 8'h3C, "R4 lo");

      // R10 unmapped
      wr(20'h32066, 8'hFF);
      rd(20'h32066, 8'h00, "R10 unmapped");
      rd(20'h32069, 8'h00, "R10 unmapped2");
      chk("R10 no side effect", ptr_out, 32'hDEADBEEF);

      // R5/R7 run, dir, ie
      wr(20'h32068, 8'h4A);
      rd(20'h32068, 8'h4A, "R5 R7 ctrl");
      chk("R7 run", {31'h0, run}, 1);
      chk("R5 dir", {31'h0, dir}, 1);
      chk("R9 irq idle", {31'h0, irq}, 0);

      // R8 done sets flag, R9 irq
      pulse_done();
      rd(20'h32068, 8'hCA, "R8 flag set");
      chk("R9 irq on", {31'h0, irq}, 1);

      // R7 write-one-to-clear keeps RUN
      wr(20'h32068, 8'hCA);
      rd(20'h32068, 8'h4A, "R7 w1c");
      chk("R9 irq off", {31'h0, irq}, 0);

      // R7 zero in bit 7 leaves flag set
      pulse_done();
      wr(20'h32068, 8'h4A);
      rd(20'h32068, 8'hCA, "R7 w0 keeps flag");

      // R11 clear and set together
      wr(20'h32068, 8'hCA, 1'b1);
      rd(20'h32068, 8'hCA, "R11 set wins");

      // R5 copy with ie cleared; flag remains, irq drops
      wr(20'h32068, 8'h02);
      rd(20'h32068, 8'h82, "R5 ie cleared");
      chk("R9 irq masked", {31'h0, irq}, 0);

      // R6 soft reset
      wr(20'h32068, 8'hCB);
      rd(20'h32068, 8'h48, "R6 ctrl");
      chk("R6 ptr reload", ptr_out, 32'h12355000);
      chk("R6 cnt clear", {16'h0, cnt_out}, 0);
      chk("R6 run off", {31'h0, run}, 0);

      // R8 done with RUN off ignored
      pulse_done();
      rd(20'h32068, 8'h48, "R8 idle done");
      chk("R8 irq stays low", {31'h0, irq}, 0);

      // R6 second base, unaligned bytes
      wr(20'h31000, 8'hAB); wr(20'h31001, 8'hCD);
      wr(20'h31002, 8'hFF); wr(20'h31003, 8'hFF);
      rd(20'h31001, 8'hCC, "R2 b1 second");
      wr(20'h32068, 8'h01);
      chk("R6 ptr reload2", ptr_out, 32'hABCD5000);
      rd(20'h32060, 8'hAB, "R6 p0 readback");
      chk("R5 dir cleared", {31'h0, dir}, 0);

      repeat (2) @(negedge clk);
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule